// File: doc/BRIEF.md
# Semi-Transparency Blend and Mask Write Stage

This block is the last step of a 2D rasteriser's pixel pipeline. It takes one foreground pixel at a time, given as 8-bit red, green and blue channels plus a semi-transparency flag (STP) and a frame-buffer address. Per-primitive controls come with it: textured or not, semi-transparency enable, a 2-bit blend mode, dither enable, and the two mask controls. The block reduces the colour to 5 bits per channel, with optional ordered dither. It then decides whether the pixel is transparent, opaque or blended, and whether a protected destination blocks it. Finally it issues the frame-buffer write.

A destination read is only made when the pixel will be blended or when mask checking is on. Pixels that need no read are accepted every cycle and written one cycle later. A pixel that needs a read holds off new input until the read data returns.

Top module: `blend_mask_unit`

## Requirements
- R1: Without dither, each output channel is the top 5 bits of its 8-bit input. Red sits in word bits 4:0, green in 9:5 and blue in 14:10. `in_rgb` carries red in 7:0, green in 15:8 and blue in 23:16.
- R2: With dither on, a signed offset is added to each 8-bit channel before reduction. The sum is clamped to 0..255. The offset is picked by (`in_dy`, `in_dx`) from rows y=0..3 of {-4,0,-3,1}, {2,-2,3,-1}, {-3,1,-4,0}, {3,-1,2,-2}, indexed by x=0..3.
- R3: A textured pixel whose reduced colour is 0 and whose STP is 0 is transparent. It gives no read and no write, whatever the semi-transparency enable.
- R4: A textured pixel is written opaque, with its own colour, in three cases: black with STP=1, non-black with STP=0, or non-black with STP=1 while semi-transparency is off.
- R5: A blended pixel combines destination B and foreground F per channel. Mode 0 gives (B+F)/2. Mode 1 gives B+F. Mode 2 gives B−F. Mode 3 gives B+F/4. Results saturate at 31 and clamp at 0.
- R6: With semi-transparency on, an untextured pixel is always blended, black included.
- R7: With mask check on, a destination whose bit 15 is 1 is never overwritten.
- R8: Written bit 15 is 1 when mask set is on. Otherwise it equals the foreground STP.
- R9: A destination read is requested only when the pixel is blended or mask check is on. A pixel without a read is written on the clock after it is accepted, and `in_ready` stays high. With a read, `rd_req` pulses on the clock after acceptance and `in_ready` stays low until `rd_valid` is seen. The write follows on the clock after `rd_valid`.
- R10: The read and the write use the address accepted with the pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel offered |
| in_ready | output | 1 | Block can accept a pixel |
| in_addr | input | ADDR_W | Frame-buffer address of the pixel |
| in_rgb | input | 24 | Foreground colour, 8 bits per channel |
| in_stp | input | 1 | Foreground STP bit |
| in_textured | input | 1 | Primitive is textured |
| in_semi | input | 1 | Semi-transparency enabled for the primitive |
| in_mode | input | 2 | Blend mode |
| in_dither | input | 1 | Dither enable |
| in_dx | input | 2 | Low bits of pixel X for dither |
| in_dy | input | 2 | Low bits of pixel Y for dither |
| mask_set | input | 1 | Force bit 15 on written pixels |
| mask_check | input | 1 | Protect destinations with bit 15 set |
| rd_req | output | 1 | Destination read request pulse |
| rd_addr | output | ADDR_W | Destination read address |
| rd_valid | input | 1 | Destination read data valid |
| rd_data | input | 16 | Destination pixel |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 16 | Pixel word to write |

## Verification
The assertions check the handshake on every cycle: a read pulse lasts one cycle and blocks input, and no read is made when neither blending nor mask checking is on. They also check that a protected destination is never written, that mask set always lands in bit 15, and that a textured black pixel with STP clear produces no traffic. The blend arithmetic, saturation and clamping, the dither offsets, and the opaque cases of the truth table are only shown by the bench scenarios. Those scenarios compare written words against values computed independently, including back-to-back acceptance without reads.

// File: rtl/blend_mask_unit.sv
module blend_mask_unit #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [23:0]       in_rgb,
  input  logic              in_stp,
  input  logic              in_textured,
  input  logic              in_semi,
  input  logic [1:0]        in_mode,
  input  logic              in_dither,
  input  logic [1:0]        in_dx,
  input  logic [1:0]        in_dy,
  input  logic              mask_set,
  input  logic              mask_check,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [15:0]       rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data
);

  localparam int CH = 5;
  localparam int WC = 3 * CH;

  typedef enum logic {S_IDLE, S_WAIT} state_t;
  state_t state;

  logic [ADDR_W-1:0] h_addr;
  logic [WC-1:0]     h_col;
  logic              h_stp, h_tex, h_semi, h_mset, h_mchk;
  logic [1:0]        h_mode;

  function automatic logic signed [3:0] dith_off(input logic [1:0] y, input logic [1:0] x);
    case ({y, x})
      4'h0: return -4; 4'h1: return  0; 4'h2: return -3; 4'h3: return  1;
      4'h4: return  2; 4'h5: return -2; 4'h6: return  3; 4'h7: return -1;
      4'h8: return -3; 4'h9: return  1; 4'hA: return -4; 4'hB: return  0;
      4'hC: return  3; 4'hD: return -1; 4'hE: return  2; default: return -2;
    endcase
  endfunction

  function automatic logic [CH-1:0] reduce(input logic [7:0] c, input logic en,
                                          input logic signed [3:0] off);
    logic signed [9:0] s;
    s = $signed({2'b00, c}) + (en ? {{6{off[3]}}, off} : 10'sd0);
    if (s < 0)          return '0;
    else if (s > 255)   return '1;
    else                return s[7:3];
  endfunction

  function automatic logic [CH-1:0] blend_ch(input logic [CH-1:0] b, input logic [CH-1:0] f,
                                            input logic [1:0] m);
    logic [CH:0] s;
    case (m)
      2'd0: begin s = {1'b0, b} + {1'b0, f}; return s[CH:1]; end
      2'd1: begin s = {1'b0, b} + {1'b0, f}; return s[CH] ? '1 : s[CH-1:0]; end
      2'd2: return (b > f) ? b - f : '0;
      default: begin s = {1'b0, b} + {3'b000, f[CH-1:2]}; return s[CH] ? '1 : s[CH-1:0]; end
    endcase
  endfunction

  logic signed [3:0] off;
  logic [WC-1:0] in_col;
  assign off    = dith_off(in_dy, in_dx);
  assign in_col = {reduce(in_rgb[23:16], in_dither, off),
                   reduce(in_rgb[15:8],  in_dither, off),
                   reduce(in_rgb[7:0],   in_dither, off)};

  logic          idle;
  logic [WC-1:0] c_col;
  logic          c_stp, c_tex, c_semi, c_mset, c_mchk;
  logic [1:0]    c_mode;
  assign idle   = (state == S_IDLE);
  assign c_col  = idle ? in_col      : h_col;
  assign c_stp  = idle ? in_stp      : h_stp;
  assign c_tex  = idle ? in_textured : h_tex;
  assign c_semi = idle ? in_semi     : h_semi;
  assign c_mode = idle ? in_mode     : h_mode;
  assign c_mset = idle ? mask_set    : h_mset;
  assign c_mchk = idle ? mask_check  : h_mchk;

  logic c_black, c_drop, c_blend, c_need_rd;
  assign c_black   = (c_col == '0);
  assign c_drop    = c_tex && !c_stp && c_black;
  assign c_blend   = c_semi && (!c_tex || (c_stp && !c_black));
  assign c_need_rd = !c_drop && (c_blend || c_mchk);

  logic [WC-1:0] mixed, out_col;
  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_ch
      assign mixed[g*CH +: CH] = blend_ch(rd_data[g*CH +: CH], c_col[g*CH +: CH], c_mode);
    end
  endgenerate
  assign out_col = c_blend ? mixed : c_col;

  logic accept;
  assign in_ready = idle;
  assign accept   = in_valid && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      h_addr  <= '0;
      h_col   <= '0;
      h_stp   <= 1'b0;
      h_tex   <= 1'b0;
      h_semi  <= 1'b0;
      h_mode  <= '0;
      h_mset  <= 1'b0;
      h_mchk  <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      wr_en  <= 1'b0;
      if (idle) begin
        if (accept) begin
          if (c_need_rd) begin
            h_addr  <= in_addr;
            h_col   <= in_col;
            h_stp   <= in_stp;
            h_tex   <= in_textured;
            h_semi  <= in_semi;
            h_mode  <= in_mode;
            h_mset  <= mask_set;
            h_mchk  <= mask_check;
            rd_req  <= 1'b1;
            rd_addr <= in_addr;
            state   <= S_WAIT;
          end else begin
            wr_en   <= !c_drop;
            wr_addr <= in_addr;
            wr_data <= {c_mset | c_stp, out_col};
          end
        end
      end else if (rd_valid) begin
        wr_en   <= !(h_mchk && rd_data[15]);
        wr_addr <= h_addr;
        wr_data <= {c_mset | c_stp, out_col};
        state   <= S_IDLE;
      end
    end
  end

  a_r9_req_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !in_ready);

  a_r9_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r9_no_needless_read: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_semi && !mask_check) |=> !rd_req);

  a_r7_mask_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && rd_valid && rd_data[15] && h_mchk) |=> !wr_en);

  a_r8_mask_set_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mask_set) |=> (rd_req || !wr_en || wr_data[15]));

  a_r8_mask_set_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && rd_valid && h_mset) |=> (!wr_en || wr_data[15]));

  a_r3_transparent_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_textured && !in_stp && !in_dither &&
     in_rgb[23:19] == 5'd0 && in_rgb[15:11] == 5'd0 && in_rgb[7:3] == 5'd0)
    |=> (!wr_en && !rd_req));

endmodule

// File: tb/blend_mask_unit_test.sv
module blend_mask_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [AW-1:0] in_addr = '0;
  logic [23:0] in_rgb = '0;
  logic in_stp = 0, in_textured = 0, in_semi = 0, in_dither = 0;
  logic [1:0] in_mode = '0, in_dx = '0, in_dy = '0;
  logic mask_set = 0, mask_check = 0;
  logic rd_req, rd_valid = 0, wr_en;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [15:0] rd_data = '0, wr_data;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blend_mask_unit #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_rgb(in_rgb), .in_stp(in_stp), .in_textured(in_textured),
    .in_semi(in_semi), .in_mode(in_mode), .in_dither(in_dither), .in_dx(in_dx),
    .in_dy(in_dy), .mask_set(mask_set), .mask_check(mask_check), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int doff(input int y, input int x);
    int t[16] = '{-4, 0, -3, 1, 2, -2, 3, -1, -3, 1, -4, 0, 3, -1, 2, -2};
    return t[y*4 + x];
  endfunction

  function automatic int red5(input int c, input bit d, input int y, input int x);
    int s = c + (d ? doff(y, x) : 0);
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s / 8;
  endfunction

  function automatic int mix(input int b, input int f, input int m);
    int r;
    case (m)
      0: r = (b + f) / 2;
      1: r = b + f;
      2: r = b - f;
      default: r = b + f / 4;
    endcase
    if (r > 31) r = 31;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic drive(input logic [23:0] rgb, input bit stp, tex, semi, input int mode,
                       input bit dith, input int dx, dy, input bit mset, mchk,
                       input logic [AW-1:0] addr);
    in_rgb = rgb; in_stp = stp; in_textured = tex; in_semi = semi; in_mode = 2'(mode);
    in_dither = dith; in_dx = 2'(dx); in_dy = 2'(dy); mask_set = mset; mask_check = mchk;
    in_addr = addr; in_valid = 1;
  endtask

  // Sends one pixel and checks read behaviour and the written word against the model.
  task automatic do_pix(input string tag, input logic [23:0] rgb, input bit stp, tex, semi,
                        input int mode, input bit dith, input int dx, dy, input bit mset, mchk,
                        input logic [15:0] dest, input logic [AW-1:0] addr);
    int r, g, b, col;
    bit black, drop, bl, need, we;
    logic [15:0] exp_w;
    r = red5(rgb[7:0], dith, dy, dx);
    g = red5(rgb[15:8], dith, dy, dx);
    b = red5(rgb[23:16], dith, dy, dx);
    col = b * 1024 + g * 32 + r;
    black = (col == 0);
    drop = tex && !stp && black;
    bl = semi && (!tex || (stp && !black));
    need = !drop && (bl || mchk);
    if (bl) col = mix(dest[14:10], b, mode) * 1024 + mix(dest[9:5], g, mode) * 32 + mix(dest[4:0], r, mode);
    exp_w = {mset | stp, 15'(col)};
    we = !drop && !(need && mchk && dest[15]);
    @(negedge clk);
    drive(rgb, stp, tex, semi, mode, dith, dx, dy, mset, mchk, addr);
    @(negedge clk);
    in_valid = 0;
    chk({"R9 read request ", tag}, 32'(rd_req), 32'(need));
    if (need) begin
      chk({"R9 ready low during read ", tag}, 32'(in_ready), 0);
      chk({"R10 read address ", tag}, 32'(rd_addr), 32'(addr));
      repeat (2) @(negedge clk);
      chk({"R9 waiting no write ", tag}, 32'(wr_en), 0);
      rd_valid = 1; rd_data = dest;
      @(negedge clk);
      rd_valid = 0;
    end
    chk({"write enable ", tag}, 32'(wr_en), 32'(we));
    if (we) begin
      chk({"data ", tag}, 32'(wr_data), 32'(exp_w));
      chk({"R10 write address ", tag}, 32'(wr_addr), 32'(addr));
    end
    chk({"R9 ready after ", tag}, 32'(in_ready), 1);
  endtask

  task automatic t_reset();
    chk("reset wr_en", 32'(wr_en), 0);
    chk("reset rd_req", 32'(rd_req), 0);
    chk("reset in_ready", 32'(in_ready), 1);
  endtask

  task automatic t_truncate();
    do_pix("R1 truncation", 24'hFF8017, 0, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0, 20'h00011);
    chk("R1 fixed value", 32'(wr_data), 32'h7E02);
    do_pix("R1 all ones", 24'hFFFFFF, 1, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0, 20'h00012);
  endtask

  task automatic t_dither();
    do_pix("R2 dither low clamp", 24'h020103, 1, 0, 0, 0, 1, 0, 0, 0, 0, 16'h0, 20'h00020);
    do_pix("R2 dither +3", 24'h0D0D0D, 1, 0, 0, 0, 1, 2, 1, 0, 0, 16'h0, 20'h00021);
    do_pix("R2 dither high clamp", 24'hFEFDFF, 1, 0, 0, 0, 1, 0, 3, 0, 0, 16'h0, 20'h00022);
    do_pix("R2 dither -1", 24'h080808, 0, 0, 0, 0, 1, 3, 1, 0, 0, 16'h0, 20'h00023);
  endtask

  task automatic t_transparency();
    do_pix("R3 black stp0 semi off", 24'h000000, 0, 1, 0, 0, 0, 0, 0, 0, 0, 16'h1234, 20'h00030);
    do_pix("R3 black stp0 semi on mask", 24'h070707, 0, 1, 1, 1, 0, 0, 0, 1, 1, 16'h1234, 20'h00031);
    do_pix("R4 black stp1", 24'h000000, 1, 1, 1, 1, 0, 0, 0, 0, 0, 16'h7FFF, 20'h00032);
    do_pix("R4 color stp0 semi on", 24'h408020, 0, 1, 1, 1, 0, 0, 0, 0, 0, 16'h7FFF, 20'h00033);
    do_pix("R4 color stp1 semi off", 24'h408020, 1, 1, 0, 1, 0, 0, 0, 0, 0, 16'h7FFF, 20'h00034);
  endtask

  task automatic t_blend();
    for (int m = 0; m < 4; m++) begin
      do_pix($sformatf("R5 mode%0d mid", m), 24'h806040, 1, 1, 1, m, 0, 0, 0, 0, 0, 16'h2D6B, 20'h00040 + 20'(m));
      do_pix($sformatf("R5 mode%0d extreme", m), 24'hF808F8, 1, 1, 1, m, 0, 0, 0, 0, 0, 16'h7C1F, 20'h00048 + 20'(m));
    end
    do_pix("R5 subtract clamp", 24'hF8F8F8, 1, 1, 1, 2, 0, 0, 0, 0, 0, 16'h0421, 20'h0004F);
  endtask

  task automatic t_untextured();
    do_pix("R6 untextured black blend", 24'h000000, 0, 0, 1, 0, 0, 0, 0, 0, 0, 16'h3DEF, 20'h00050);
    do_pix("R6 untextured add", 24'h101010, 0, 0, 1, 1, 0, 0, 0, 0, 0, 16'h3DEF, 20'h00051);
  endtask

  task automatic t_mask();
    do_pix("R7 protected dest", 24'h808080, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h8000, 20'h00060);
    do_pix("R7 unprotected dest", 24'h808080, 0, 0, 0, 0, 0, 0, 0, 0, 1, 16'h7FFF, 20'h00061);
    do_pix("R7 blend protected", 24'h808080, 1, 1, 1, 1, 0, 0, 0, 1, 1, 16'hFFFF, 20'h00062);
    do_pix("R8 mask set direct", 24'h204060, 0, 0, 0, 0, 0, 0, 0, 1, 0, 16'h0, 20'h00063);
    do_pix("R8 mask set after read", 24'h204060, 0, 1, 1, 3, 0, 0, 0, 1, 1, 16'h0C63, 20'h00064);
    do_pix("R8 stp passes through", 24'h204060, 1, 0, 0, 0, 0, 0, 0, 0, 0, 16'h0, 20'h00065);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    drive(24'h0000F8, 0, 0, 0, 0, 0, 0, 0, 0, 0, 20'h00070);
    @(negedge clk);
    chk("R9 first write next cycle", 32'(wr_en), 1);
    chk("R9 first data", 32'(wr_data), 32'h001F);
    chk("R9 ready stays high", 32'(in_ready), 1);
    drive(24'hF80000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 20'h00071);
    @(negedge clk);
    in_valid = 0;
    chk("R9 second write", 32'(wr_en), 1);
    chk("R9 second data", 32'(wr_data), 32'hFC00);
    chk("R10 second address", 32'(wr_addr), 32'h00071);
    @(negedge clk);
    chk("R9 no extra write", 32'(wr_en), 0);
  endtask

  task automatic t_stray_read_data();
    @(negedge clk);
    rd_valid = 1; rd_data = 16'hFFFF;
    @(negedge clk);
    rd_valid = 0;
    chk("R9 idle read data ignored", 32'(wr_en), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_truncate();
    t_dither();
    t_transparency();
    t_blend();
    t_untextured();
    t_mask();
    t_back_to_back();
    t_stray_read_data();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule